// File: doc/BRIEF.md
# Receive Dword FIFO with Header Skip and Frame Rewind

This block buffers 32-bit dwords arriving from a serial-link transport receive path and hands them to a DMA read port. Every dword of an incoming frame is stored, the header dword included. What the reader sees depends on the kind of frame, which the writer tags on the first dword. For a payload frame, the header is kept out of the reader's view. The read side steps over it on its own, so the first dword delivered is payload. For an interlocked frame, the reader may already have consumed part of the frame when its last dword is written. In that case the read pointer is moved back to the frame's first dword, and the reader gets the whole frame again starting from the header.

Frames have no size limit. A payload or plain frame longer than the storage streams through, because the write side is held off by backpressure. While the reader is inside an open interlocked frame, the frame's first dword stays protected from overwrite so the rewind target survives. An interlocked frame must therefore fit in the storage. Frame-kind decoding and the link handshake belong to neighbouring logic.

Top module: `rx_hdr_fifo`

## Requirements
- R1: While and right after reset: `empty`=1, `full`=0, `rd_valid`=0 and `wr_ready`=1.
- R2: Dwords of plain frames (`wr_kind` 2'b00 or 2'b11 on the start dword) are delivered on the read port in write order, each exactly once, on cycles where `rd_valid` and `rd_ready` are both 1.
- R3: The start dword of a payload frame (`wr_kind`=2'b01 with `wr_sof`=1) is never presented on the read port. The following dword of that frame is the first one presented, and the skipped header is not counted as a delivered dword.
- R4: Consider an interlocked frame (`wr_kind`=2'b10 on its start dword) from which the reader has taken at least one dword. When its end dword (`wr_eof`=1) is accepted, the next dword presented is that frame's start dword, and the frame is then delivered in full from there.
- R5: The rewind has no effect when the reader has taken no dword of the interlocked frame. This includes a one-dword frame, with `wr_sof` and `wr_eof` together, and a frame written while older dwords are still unread. Delivery then simply continues in order.
- R6: When a read handshake and the rewind fall in the same cycle, the dword handed over in that cycle counts as delivered, and the next dword presented is the frame's start dword.
- R7: `empty`=1 exactly when no dword is stored, and `rd_valid` is never 1 while `empty`=1. `full`=1 exactly when DEPTH dwords are held. While the reader is inside an open interlocked frame, the held dwords are counted from that frame's start dword.
- R8: A write is accepted only on a cycle with `wr_valid`=1 and `wr_ready`=1, where `wr_ready` is the inverse of `full`. A frame of any length streams through without loss while the reader drains.
- R9: While `rd_valid`=1 and `rd_ready`=0, `rd_valid` and `rd_data` hold their values into the next cycle, unless an end dword is accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Write dword offered |
| wr_ready | output | 1 | Write dword can be accepted |
| wr_data | input | 32 | Write dword |
| wr_sof | input | 1 | Dword is the first of a frame |
| wr_eof | input | 1 | Dword is the last of a frame |
| wr_kind | input | 2 | Frame kind on the start dword: 00 plain, 01 payload, 10 interlocked, 11 plain |
| rd_valid | output | 1 | Read dword presented |
| rd_ready | input | 1 | Reader takes the presented dword |
| rd_data | output | 32 | Read dword |
| empty | output | 1 | No dword stored |
| full | output | 1 | Storage full |

## Verification
Two things can happen on the same clock edge. The reader takes a dword of an interlocked frame, and the end dword of that frame is written, which triggers the rewind. The bench provokes this by writing a three-dword interlocked frame back to back while `rd_ready` is held high, so the second dword is taken in the cycle the end dword is accepted. The delivered sequence must show that dword once before the rewind and then again after the header. A behavioural reference model built on unbounded integers also runs alongside the design and is compared every cycle. It covers the other overlap as well: a header skip in the same cycle as a write.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int unsigned DWORD_W = 32;

    typedef enum logic [1:0] {
        FK_PLAIN = 2'b00,
        FK_DATA  = 2'b01,
        FK_ILK   = 2'b10,
        FK_RSVD  = 2'b11
    } fkind_e;

    typedef struct packed {
        logic               hide;
        logic [DWORD_W-1:0] word;
    } slot_t;

    function automatic logic kind_hides_header(fkind_e k);
        return k == FK_DATA;
    endfunction

    function automatic logic kind_interlocked(fkind_e k);
        return k == FK_ILK;
    endfunction

endpackage

// File: rtl/rxf_slot_ram.sv
module rxf_slot_ram
    import rxf_pkg::*;
#(
    parameter int unsigned AW = 3
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  slot_t         wslot,
    input  logic [AW-1:0] raddr,
    output slot_t         rslot
);
    localparam int unsigned DEPTH = 1 << AW;

    slot_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wslot;
        end
    end

    assign rslot = mem[raddr];

endmodule

// File: rtl/rxf_frame_track.sv
module rxf_frame_track
    import rxf_pkg::*;
#(
    parameter int unsigned PW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wfire,
    input  logic          sof,
    input  logic          eof,
    input  fkind_e        kind_in,
    input  logic [PW-1:0] wptr,
    output logic [PW-1:0] frame_base,
    output logic          ilk_open,
    output logic [PW-1:0] cur_start,
    output fkind_e        cur_kind
);
    logic          open_q;
    fkind_e        kind_q;
    logic [PW-1:0] start_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q  <= 1'b0;
            kind_q  <= FK_PLAIN;
            start_q <= '0;
        end else if (wfire) begin
            open_q <= !eof;
            if (sof) begin
                start_q <= wptr;
                kind_q  <= kind_in;
            end
        end
    end

    assign frame_base = start_q;
    assign ilk_open   = open_q && kind_interlocked(kind_q);
    assign cur_start  = sof ? wptr : start_q;
    assign cur_kind   = sof ? kind_in : kind_q;

endmodule

// File: rtl/rxf_ptr_ctl.sv
module rxf_ptr_ctl #(
    parameter int unsigned AW = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_req,
    input  logic        rd_take,
    input  logic        head_hidden,
    input  logic        eof_ilk,
    input  logic [AW:0] cur_start,
    input  logic [AW:0] frame_base,
    input  logic        ilk_open,
    output logic [AW:0] wptr,
    output logic [AW:0] rptr,
    output logic        wfire,
    output logic        full,
    output logic        empty
);
    localparam int unsigned PW    = AW + 1;
    localparam int unsigned DEPTH = 1 << AW;

    logic [PW-1:0] dist_r, dist_w, base, used;
    logic [PW-1:0] rw_dist, rw_span;
    logic          guard, rewind, skip, adv;

    always_comb begin
        dist_r  = rptr - frame_base;
        dist_w  = wptr - frame_base;
        guard   = ilk_open && (dist_r <= dist_w);
        base    = guard ? frame_base : rptr;
        used    = wptr - base;
        full    = (used == PW'(DEPTH));
        empty   = (wptr == rptr);
        wfire   = wr_req && !full;
        rw_dist = rptr - cur_start;
        rw_span = wptr - cur_start;
        rewind  = wfire && eof_ilk && (rw_dist != '0) && (rw_dist <= rw_span);
        skip    = !empty && head_hidden;
        adv     = rd_take || skip;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (wfire) begin
                wptr <= wptr + PW'(1);
            end
            if (rewind) begin
                rptr <= cur_start;
            end else if (adv) begin
                rptr <= rptr + PW'(1);
            end
        end
    end

endmodule

// File: rtl/rx_hdr_fifo.sv
module rx_hdr_fifo
    import rxf_pkg::*;
#(
    parameter int unsigned DEPTH_LOG2 = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_valid,
    output logic               wr_ready,
    input  logic [DWORD_W-1:0] wr_data,
    input  logic               wr_sof,
    input  logic               wr_eof,
    input  logic [1:0]         wr_kind,
    output logic               rd_valid,
    input  logic               rd_ready,
    output logic [DWORD_W-1:0] rd_data,
    output logic               empty,
    output logic               full
);
    localparam int unsigned AW = DEPTH_LOG2;
    localparam int unsigned PW = AW + 1;

    logic [PW-1:0] wptr, rptr, frame_base, cur_start;
    logic          wfire, ilk_open, rd_take;
    fkind_e        kind_in, cur_kind;
    slot_t         wslot, rslot;

    assign kind_in = fkind_e'(wr_kind);
    assign wslot   = '{hide: wr_sof && kind_hides_header(kind_in), word: wr_data};

    rxf_frame_track #(.PW(PW)) u_track (
        .clk        (clk),
        .rst        (rst),
        .wfire      (wfire),
        .sof        (wr_sof),
        .eof        (wr_eof),
        .kind_in    (kind_in),
        .wptr       (wptr),
        .frame_base (frame_base),
        .ilk_open   (ilk_open),
        .cur_start  (cur_start),
        .cur_kind   (cur_kind)
    );

    rxf_ptr_ctl #(.AW(AW)) u_ptr (
        .clk         (clk),
        .rst         (rst),
        .wr_req      (wr_valid),
        .rd_take     (rd_take),
        .head_hidden (rslot.hide),
        .eof_ilk     (wr_eof && kind_interlocked(cur_kind)),
        .cur_start   (cur_start),
        .frame_base  (frame_base),
        .ilk_open    (ilk_open),
        .wptr        (wptr),
        .rptr        (rptr),
        .wfire       (wfire),
        .full        (full),
        .empty       (empty)
    );

    rxf_slot_ram #(.AW(AW)) u_ram (
        .clk   (clk),
        .we    (wfire),
        .waddr (wptr[AW-1:0]),
        .wslot (wslot),
        .raddr (rptr[AW-1:0]),
        .rslot (rslot)
    );

    assign wr_ready = !full;
    assign rd_valid = !empty && !rslot.hide;
    assign rd_data  = rslot.word;
    assign rd_take  = rd_valid && rd_ready;

endmodule

// File: rtl/rx_hdr_fifo_chk.sv
module rx_hdr_fifo_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_valid,
    input logic        wr_ready,
    input logic        wr_eof,
    input logic        rd_valid,
    input logic        rd_ready,
    input logic [31:0] rd_data,
    input logic        empty,
    input logic        full
);
    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (empty && !full && !rd_valid && wr_ready));

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        full |-> !wr_ready);

    p_empty_novalid_r7: assert property (@(posedge clk) disable iff (rst)
        empty |-> !rd_valid);

    p_flags_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
        !(empty && full));

    p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready && !(wr_valid && wr_ready && wr_eof))
        |=> (rd_valid && $stable(rd_data)));

endmodule

bind rx_hdr_fifo rx_hdr_fifo_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_eof   (wr_eof),
    .rd_valid (rd_valid),
    .rd_ready (rd_ready),
    .rd_data  (rd_data),
    .empty    (empty),
    .full     (full)
);

// File: tb/tb_rx_hdr_fifo.sv
module tb_rx_hdr_fifo;
    localparam int DL = 3;
    localparam int DEPTH = 1 << DL;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_valid = 1'b0, wr_sof = 1'b0, wr_eof = 1'b0, rd_ready = 1'b0;
    logic [31:0] wr_data = '0;
    logic [1:0]  wr_kind = 2'b00;
    logic        wr_ready, rd_valid, empty, full;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;
    int rd_mode = 0;
    logic [15:0] lfsr = 16'hACE1;

    logic [31:0] got[$];
    logic [31:0] want[$];

    // reference model state
    int m_wp = 0, m_rp = 0, m_fs = 0, m_kd = 0;
    bit m_op = 0;
    logic [31:0] m_d[int];
    bit m_h[int];

    always #2 clk = ~clk;

    rx_hdr_fifo #(.DEPTH_LOG2(DL)) dut (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_data(wr_data), .wr_sof(wr_sof), .wr_eof(wr_eof), .wr_kind(wr_kind),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .empty(empty), .full(full)
    );

    function automatic bit e_empty();
        return m_wp == m_rp;
    endfunction

    function automatic bit e_full();
        int base;
        base = (m_op && m_kd == 2 && m_rp >= m_fs) ? m_fs : m_rp;
        return (m_wp - base) >= DEPTH;
    endfunction

    function automatic bit e_hidden();
        return !e_empty() && m_h.exists(m_rp) && m_h[m_rp];
    endfunction

    function automatic bit e_valid();
        return !e_empty() && !e_hidden();
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // model update on every clock
    always @(posedge clk) begin
        if (rst) begin
            m_wp = 0; m_rp = 0; m_fs = 0; m_kd = 0; m_op = 0;
        end else begin
            bit wf, rf, sk;
            int nrp, st, k;
            wf = wr_valid && !e_full();
            rf = e_valid() && rd_ready;
            sk = e_hidden();
            nrp = m_rp + ((rf || sk) ? 1 : 0);
            if (wf) begin
                st = wr_sof ? m_wp : m_fs;
                k  = wr_sof ? int'(wr_kind) : m_kd;
                m_d[m_wp] = wr_data;
                m_h[m_wp] = wr_sof && (wr_kind == 2'b01);
                if (wr_eof && k == 2 && m_rp > st) nrp = st;
                if (wr_sof) begin m_fs = m_wp; m_kd = int'(wr_kind); end
                m_op = !wr_eof;
                m_wp++;
            end
            m_rp = nrp;
        end
    end

    // per-cycle compare, reader drive and delivery log
    always @(negedge clk) begin
        if (!rst) begin
            chk("R7 empty", {31'd0, empty}, {31'd0, e_empty()});
            chk("R7 full", {31'd0, full}, {31'd0, e_full()});
            chk("R8 wr_ready", {31'd0, wr_ready}, {31'd0, !e_full()});
            chk("R2 rd_valid", {31'd0, rd_valid}, {31'd0, e_valid()});
            if (e_valid()) chk("R2 rd_data", rd_data, m_d[m_rp]);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            rd_ready = (rd_mode == 1) ? 1'b1 : (rd_mode == 2) ? lfsr[0] : 1'b0;
            if (rd_valid && rd_ready) got.push_back(rd_data);
        end
    end

    task automatic send_word(input logic [31:0] d, input logic s, input logic e, input logic [1:0] k);
        bit acc;
        acc = 0;
        while (!acc) begin
            @(negedge clk);
            wr_valid = 1'b1; wr_data = d; wr_sof = s; wr_eof = e; wr_kind = k;
            #1;
            acc = wr_ready;
            @(posedge clk);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            wr_valid = 1'b0; wr_sof = 1'b0; wr_eof = 1'b0;
        end
    endtask

    task automatic send_frame(input int n, input logic [1:0] k, input logic [31:0] b, input int gap);
        for (int i = 0; i < n; i++) begin
            send_word(b + i, i == 0, i == n - 1, k);
            if (gap > 0) idle(gap);
        end
        idle(1);
    endtask

    task automatic check_seq(input string tag);
        chk({tag, " count"}, got.size(), want.size());
        for (int i = 0; i < want.size() && i < got.size(); i++)
            chk(tag, got[i], want[i]);
        got.delete();
        want.delete();
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        errors++;
        $display("FAIL R8 watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state during reset
        chk("R1 empty", {31'd0, empty}, 32'd1);
        chk("R1 full", {31'd0, full}, 32'd0);
        chk("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
        chk("R1 wr_ready", {31'd0, wr_ready}, 32'd1);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 empty after", {31'd0, empty}, 32'd1);

        // R2: plain frame in order
        rd_mode = 1;
        send_frame(3, 2'b00, 32'h100, 0);
        idle(6);
        for (int i = 0; i < 3; i++) want.push_back(32'h100 + i);
        check_seq("R2 plain order");

        // R3: payload frame header hidden
        send_frame(4, 2'b01, 32'h200, 0);
        idle(6);
        for (int i = 1; i < 4; i++) want.push_back(32'h200 + i);
        check_seq("R3 header skip");

        // R4: interlocked frame, reader inside before end dword
        send_frame(4, 2'b10, 32'h300, 3);
        idle(10);
        for (int i = 0; i < 3; i++) want.push_back(32'h300 + i);
        for (int i = 0; i < 4; i++) want.push_back(32'h300 + i);
        check_seq("R4 rewind");

        // R6: read handshake and rewind in the same cycle
        send_frame(3, 2'b10, 32'h400, 0);
        idle(8);
        want.push_back(32'h400); want.push_back(32'h401);
        want.push_back(32'h400); want.push_back(32'h401); want.push_back(32'h402);
        check_seq("R6 read with rewind");

        // R5: nothing of the frame consumed, older data unread
        rd_mode = 0;
        idle(2);
        send_frame(2, 2'b00, 32'h500, 0);
        send_frame(3, 2'b10, 32'h510, 0);
        rd_mode = 1;
        idle(10);
        want.push_back(32'h500); want.push_back(32'h501);
        for (int i = 0; i < 3; i++) want.push_back(32'h510 + i);
        check_seq("R5 no rewind");

        // R5: single-dword interlocked frame
        send_frame(1, 2'b10, 32'h600, 0);
        idle(5);
        want.push_back(32'h600);
        check_seq("R5 single dword");

        // R7/R8: fill to full with reader stalled, then drain
        rd_mode = 0;
        idle(2);
        fork
            send_frame(10, 2'b00, 32'h700, 0);
        join_none
        repeat (15) @(negedge clk);
        #1;
        chk("R7 full reached", {31'd0, full}, 32'd1);
        chk("R8 held off", {31'd0, wr_ready}, 32'd0);
        rd_mode = 2;
        wait fork;
        idle(40);
        for (int i = 0; i < 10; i++) want.push_back(32'h700 + i);
        check_seq("R8 backpressure");

        // R8/R9: long payload frame with random reader stalls
        send_frame(20, 2'b01, 32'h800, 0);
        idle(60);
        for (int i = 1; i < 20; i++) want.push_back(32'h800 + i);
        check_seq("R8 long frame");

        // R9: interlocked rewind under random stalls
        send_frame(5, 2'b10, 32'h900, 1);
        idle(40);
        chk("R9 drained", {31'd0, empty}, 32'd1);
        got.delete();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule